// File: doc/BRIEF.md
# Duplicate Packet Receive Filter

This block sits behind the CRC check on the receive side of an acknowledged radio link. The transmitter resends a packet when no acknowledgement reaches it. A resend can arrive after the receiver already took the first copy, because the acknowledgement was lost on the way back. The filter tells a fresh packet from such a resend. It keeps the address, packet identifier and full payload of the last packet it accepted. A fresh packet goes to the receive FIFO and pulses the ready flag. A resend gets an acknowledgement, but nothing else happens to it.

The stored reference never ages out. An identical packet is still dropped however long after the original it arrives. The reference changes only when a packet is accepted. Reset empties it, so the first packet after reset always counts as fresh.

When the FIFO reports full, a fresh packet is refused. It gets no acknowledgement, so the transmitter will retry it later. The reference is left alone in that case.

All three outputs are registered. A packet presented on cycle N is answered on cycle N+1.

Top module: `dup_rx_filter`

## Requirements
- R1: While reset is held and right after it, `ack_req`, `fifo_push` and `rx_ready` are 0 and no reference is stored.
- R2: The first packet after reset is accepted when `fifo_full` is 0, even if it equals a packet accepted before the reset.
- R3: A packet whose address, identifier and payload all equal those of the last accepted packet is a duplicate. The cycle after it, `ack_req` is 1 while `fifo_push` and `rx_ready` are 0.
- R4: A packet that differs from the reference only in its identifier is accepted.
- R5: A packet that differs from the reference only in its address, or only in its payload, is accepted.
- R6: Duplicate matching has no time limit. A duplicate presented after any number of idle cycles is still dropped.
- R7: A non-duplicate packet that arrives while `fifo_full` is 1 produces no `ack_req` and no `fifo_push`, and the reference stays unchanged.
- R8: A duplicate that arrives while `fifo_full` is 1 is still acknowledged.
- R9: An accepted packet yields `ack_req`, `fifo_push` and `rx_ready` all at 1 exactly one cycle later, with `fifo_data` equal to its payload.
- R10: In a cycle following one without `pkt_valid`, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | A CRC-clean packet is presented this cycle |
| pkt_addr | input | ADDR_W | Packet address |
| pkt_pid | input | PID_W | Packet identifier |
| pkt_data | input | PLD_BYTES*8 | Packet payload |
| fifo_full | input | 1 | Receive FIFO cannot take another entry |
| ack_req | output | 1 | Request to send an acknowledgement |
| fifo_push | output | 1 | Write strobe to the receive FIFO |
| fifo_data | output | PLD_BYTES*8 | Payload to write into the FIFO |
| rx_ready | output | 1 | One-cycle pulse when a new packet was taken |

## Verification
The embedded assertions check several properties on every cycle:
- no push follows a cycle where the FIFO was full;
- all outputs are quiet after an idle cycle;
- a push always carries the payload from the cycle before;
- a push always comes with an acknowledgement;
- the first packet after reset is always taken.

Classifying a packet as a duplicate needs the packet history, so the scoreboard scenarios cover it:
- a resend after a long idle gap;
- an identifier-only change;
- address-only and payload-only changes;
- a refused packet that leaves the old reference in force;
- a reset that forgets the reference.

// File: rtl/dup_rx_filter.sv
module dup_rx_filter #(
  parameter int ADDR_W    = 40,
  parameter int PID_W     = 2,
  parameter int PLD_BYTES = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pkt_valid,
  input  logic [ADDR_W-1:0]      pkt_addr,
  input  logic [PID_W-1:0]       pkt_pid,
  input  logic [PLD_BYTES*8-1:0] pkt_data,
  input  logic                   fifo_full,
  output logic                   ack_req,
  output logic                   fifo_push,
  output logic [PLD_BYTES*8-1:0] fifo_data,
  output logic                   rx_ready
);
  localparam int PLD_W = PLD_BYTES * 8;

  logic              ref_valid;
  logic [ADDR_W-1:0] ref_addr;
  logic [PID_W-1:0]  ref_pid;
  logic [PLD_W-1:0]  ref_data;

  wire is_dup = ref_valid && (pkt_addr == ref_addr) && (pkt_pid == ref_pid) && (pkt_data == ref_data);
  wire take   = pkt_valid && !is_dup && !fifo_full;
  wire ack_nx = pkt_valid && (is_dup || !fifo_full);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_valid <= 1'b0;
      ref_addr  <= '0;
      ref_pid   <= '0;
      ref_data  <= '0;
      ack_req   <= 1'b0;
      fifo_push <= 1'b0;
      rx_ready  <= 1'b0;
      fifo_data <= '0;
    end else begin
      ack_req   <= ack_nx;
      fifo_push <= take;
      rx_ready  <= take;
      if (take) begin
        ref_valid <= 1'b1;
        ref_addr  <= pkt_addr;
        ref_pid   <= pkt_pid;
        ref_data  <= pkt_data;
        fifo_data <= pkt_data;
      end
    end
  end

  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && fifo_full) |=> !fifo_push); // R7

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |=> (!ack_req && !fifo_push && !rx_ready)); // R10

  AST_PUSH_CARRIES_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> (fifo_push -> fifo_data == $past(pkt_data))); // R9

  AST_PUSH_IS_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_push || rx_ready) |-> ack_req); // R9

  AST_FIRST_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !ref_valid && !fifo_full) |=> (fifo_push && rx_ready)); // R2
endmodule

// File: tb/dup_rx_filter_tb_top.sv
module dup_rx_filter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 40;
  localparam int PID_W = 2;
  localparam int PLD_W = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pkt_valid = 1'b0;
  logic [ADDR_W-1:0] pkt_addr = '0;
  logic [PID_W-1:0] pkt_pid = '0;
  logic [PLD_W-1:0] pkt_data = '0;
  logic fifo_full = 1'b0;
  logic ack_req, fifo_push, rx_ready;
  logic [PLD_W-1:0] fifo_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  dup_rx_filter #(.ADDR_W(ADDR_W), .PID_W(PID_W), .PLD_BYTES(PLD_W/8)) dut_i (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_addr(pkt_addr),
    .pkt_pid(pkt_pid), .pkt_data(pkt_data), .fifo_full(fifo_full),
    .ack_req(ack_req), .fifo_push(fifo_push), .fifo_data(fifo_data), .rx_ready(rx_ready));

  typedef struct packed {
    logic ack;
    logic push;
    logic [PLD_W-1:0] data;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic m_valid = 1'b0;
  logic [ADDR_W-1:0] m_addr;
  logic [PID_W-1:0] m_pid;
  logic [PLD_W-1:0] m_data;

  task automatic check(input bit ok, input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic send(input logic [ADDR_W-1:0] a, input logic [PID_W-1:0] p,
                      input logic [PLD_W-1:0] d, input bit full, input string tag);
    exp_t e;
    bit dup;
    @(negedge clk);
    pkt_valid = 1'b1; pkt_addr = a; pkt_pid = p; pkt_data = d; fifo_full = full;
    dup = m_valid && a == m_addr && p == m_pid && d == m_data;
    e.data = d;
    if (dup) begin e.ack = 1'b1; e.push = 1'b0; end
    else if (full) begin e.ack = 1'b0; e.push = 1'b0; end
    else begin
      e.ack = 1'b1; e.push = 1'b1;
      m_valid = 1'b1; m_addr = a; m_pid = p; m_data = d;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n, input string tag);
    exp_t e;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pkt_valid = 1'b0; fifo_full = 1'b0;
      e.ack = 1'b0; e.push = 1'b0; e.data = '0;
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(ack_req == e.ack, t, "ack_req", 64'(ack_req), 64'(e.ack));
        check(fifo_push == e.push, t, "fifo_push", 64'(fifo_push), 64'(e.push));
        check(rx_ready == e.push, t, "rx_ready", 64'(rx_ready), 64'(e.push));
        if (e.push)
          check(fifo_data == e.data, t, "fifo_data", fifo_data[63:0], e.data[63:0]);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [PLD_W-1:0] d1, d2, d3;
    d1 = {8{32'hA5A5_1234}};
    d2 = {8{32'h0BAD_F00D}};
    d3 = {8{32'h1357_9BDF}};
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(!ack_req && !fifo_push && !rx_ready, "R1", "outputs in reset", 64'({ack_req, fifo_push, rx_ready}), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    m_valid = 1'b0;

    send(40'hE7E7E7E7E7, 2'd0, d1, 1'b0, "R2");
    send(40'hE7E7E7E7E7, 2'd0, d1, 1'b0, "R3");
    idle(60, "R10");
    send(40'hE7E7E7E7E7, 2'd0, d1, 1'b0, "R6");
    send(40'hE7E7E7E7E7, 2'd1, d1, 1'b0, "R4");
    send(40'hC2C2C2C2C2, 2'd1, d1, 1'b0, "R5");
    send(40'hC2C2C2C2C2, 2'd1, d2, 1'b0, "R5");
    send(40'hC2C2C2C2C2, 2'd1, d2, 1'b0, "R3");
    send(40'h1122334455, 2'd2, d3, 1'b1, "R7");
    send(40'hC2C2C2C2C2, 2'd1, d2, 1'b1, "R8");
    send(40'hC2C2C2C2C2, 2'd1, d2, 1'b0, "R7");
    send(40'h1122334455, 2'd2, d3, 1'b0, "R7");
    send(40'h1122334455, 2'd2, d3, 1'b0, "R3");
    idle(2, "R10");
    @(posedge clk); #2;

    @(negedge clk);
    rst_n = 1'b0;
    m_valid = 1'b0;
    @(negedge clk);
    #1;
    check(!ack_req && !fifo_push && !rx_ready, "R1", "outputs after mid reset", 64'({ack_req, fifo_push, rx_ready}), 64'd0);
    rst_n = 1'b1;
    send(40'h1122334455, 2'd2, d3, 1'b0, "R2");
    send(40'h1122334455, 2'd2, d3, 1'b0, "R3");
    idle(3, "R10");
    repeat (3) @(posedge clk);
    #2;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule